// File: doc/BRIEF.md
# PWM Compare and Event Trigger Unit

This block watches the counter of the reference synchronous PWM channel and compares it, on every reference-clock enable, against a bank of independently programmed compare values. Each comparator can be switched on or off, and it can ignore matches made while the counter counts up, while it counts down, or both. A match sets a sticky interrupt flag. A match can also pulse one or both of two event lines that start ADC conversions, with no tie to the PWM outputs. A match can also raise a DMA transfer request.

Software programs the block through a simple register port. Write and read strobes are single-cycle, and read data is returned one cycle after the strobe. Each comparator has its own configuration word. Each event line and the DMA request has its own comparator-select mask. Interrupt flags clear when the status word is read, and an interrupt-enable mask decides which flags drive the interrupt line. The block does not generate any PWM waveform. It only takes the reference counter value, its direction and its clock enable.

Top module: `pwm_cmp_evt`

## Requirements
- R1: After synchronous reset every configuration word, mask, interrupt flag, event line, DMA request and the interrupt output is zero.
- R2: Comparator i (address i, 0..7) holds its compare value in bits [15:0], its enable in bit 16, an ignore-when-counting-up bit in bit 17 and an ignore-when-counting-down bit in bit 18. It matches in a cycle with cnt_tick high, enable set, cnt_val equal to the value, and no ignore bit set for the current cnt_down (0 = up, 1 = down).
- R3: A comparator whose enable bit is clear never sets a flag, pulses an event line or raises the DMA request, even when the counter equals its value.
- R4: With cnt_tick low, no comparator matches, whatever cnt_val is.
- R5: Event line k (mask at address 8+k, bit i selects comparator i) is high for exactly the one cycle after a tick in which any selected comparator matches.
- R6: dma_req (mask at address 10) is high for the one cycle after a tick in which any selected comparator matches.
- R7: Bit i of irq_flags is set one cycle after comparator i matches and stays set until the status word (address 11) is read. The read returns the flags in bits [7:0] and clears them, except for a flag whose match happens in the cycle of the read, which stays set.
- R8: irq is high exactly when some flag bit is set whose bit is also set in the interrupt-enable mask at address 12.
- R9: A read returns, on reg_rdata one cycle after reg_rd_en, the word last written to any configuration, mask or enable address, with unused bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | Reference-channel clock enable |
| cnt_val | input | 16 | Reference-channel counter value |
| cnt_down | input | 1 | Reference counter direction, 1 = counting down |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq_flags | output | 8 | Sticky match flags |
| irq | output | 1 | Interrupt request |
| evt_pulse | output | 2 | Event trigger lines |
| dma_req | output | 1 | DMA transfer request |

## Verification
On every cycle the assertions check that event pulses, DMA requests and newly set flags follow only a tick. They also check that a flag falls only after a status read, that a read with no tick leaves all flags clear, and that irq never rises without a flag. Whether the right comparator fired at the right counter value, with the direction filters and enable bits applied, can only be shown by the bench. It sweeps the counter up and down over all programmed values and compares every output against an arithmetic model of the masks and configurations.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;
  localparam int NUM_EVT_LINES = 2;

  // Direction filter: a match is allowed unless the current direction is blocked.
  function automatic logic dir_allowed(input logic down, input logic blk_up,
                                       input logic blk_dn);
    return down ? ~blk_dn : ~blk_up;
  endfunction
endpackage

// File: rtl/pwm_cmp_unit.sv
module pwm_cmp_unit #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cnt_tick,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              cnt_down,
  output logic              hit,
  output logic [CNT_W+2:0]  cfg_o
);
  import pwm_cmp_pkg::*;

  logic [CNT_W-1:0] val_q;
  logic             en_q;
  logic             blk_up_q;
  logic             blk_dn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q    <= '0;
      en_q     <= 1'b0;
      blk_up_q <= 1'b0;
      blk_dn_q <= 1'b0;
    end else if (cfg_we) begin
      val_q    <= wdata[CNT_W-1:0];
      en_q     <= wdata[CNT_W];
      blk_up_q <= wdata[CNT_W+1];
      blk_dn_q <= wdata[CNT_W+2];
    end
  end

  always_comb begin
    hit = cnt_tick & en_q & (cnt_val == val_q)
          & dir_allowed(cnt_down, blk_up_q, blk_dn_q);
  end

  assign cfg_o = {blk_dn_q, blk_up_q, en_q, val_q};
endmodule

// File: rtl/pwm_cmp_route.sv
module pwm_cmp_route #(
  parameter int NUM_CMP   = 8,
  parameter int NUM_LINES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CMP-1:0]   hit,
  input  logic [NUM_CMP-1:0]   mask [NUM_LINES],
  output logic [NUM_LINES-1:0] pulse_q
);
  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) pulse_q[k] <= 1'b0;
      else     pulse_q[k] <= |(hit & mask[k]);
    end
  end
endmodule

// File: rtl/pwm_cmp_status.sv
module pwm_cmp_status #(
  parameter int NUM_CMP = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CMP-1:0] hit,
  input  logic               rd_clr,
  input  logic [NUM_CMP-1:0] ien,
  output logic [NUM_CMP-1:0] flags_q,
  output logic               irq_q
);
  logic [NUM_CMP-1:0] flags_d;

  always_comb begin
    flags_d = (rd_clr ? '0 : flags_q) | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irq_q   <= |(flags_d & ien);
    end
  end
endmodule

// File: rtl/pwm_cmp_evt.sv
module pwm_cmp_evt #(
  parameter int NUM_CMP = 8,
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                cnt_tick,
  input  logic [CNT_W-1:0]                    cnt_val,
  input  logic                                cnt_down,
  input  logic                                reg_wr_en,
  input  logic                                reg_rd_en,
  input  logic [ADDR_W-1:0]                   reg_addr,
  input  logic [DATA_W-1:0]                   reg_wdata,
  output logic [DATA_W-1:0]                   reg_rdata,
  output logic [NUM_CMP-1:0]                  irq_flags,
  output logic                                irq,
  output logic [pwm_cmp_pkg::NUM_EVT_LINES-1:0] evt_pulse,
  output logic                                dma_req
);
  import pwm_cmp_pkg::*;

  localparam int IDX_W = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1;
  localparam int CFG_W = CNT_W + 3;
  localparam logic [ADDR_W-1:0] A_EVT0 = ADDR_W'(NUM_CMP);
  localparam logic [ADDR_W-1:0] A_DMA  = ADDR_W'(NUM_CMP + NUM_EVT_LINES);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NUM_CMP + NUM_EVT_LINES + 1);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(NUM_CMP + NUM_EVT_LINES + 2);
  localparam logic [ADDR_W-1:0] A_NCMP = ADDR_W'(NUM_CMP);

  logic [NUM_CMP-1:0] hit;
  logic [CFG_W-1:0]   cfg_rd [NUM_CMP];
  logic [NUM_CMP-1:0] evt_mask_q [NUM_EVT_LINES];
  logic [NUM_CMP-1:0] dma_mask_q [1];
  logic [NUM_CMP-1:0] ien_q;
  logic               stat_rd;
  logic [0:0]         dma_pulse;

  // Comparator bank
  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    logic we_i;
    assign we_i = reg_wr_en && (reg_addr == ADDR_W'(i));
    pwm_cmp_unit #(.CNT_W(CNT_W), .DATA_W(DATA_W)) unit_i (
      .clk     (clk),
      .rst     (rst),
      .cfg_we  (we_i),
      .wdata   (reg_wdata),
      .cnt_tick(cnt_tick),
      .cnt_val (cnt_val),
      .cnt_down(cnt_down),
      .hit     (hit[i]),
      .cfg_o   (cfg_rd[i])
    );
  end

  // Mask and enable registers
  for (genvar k = 0; k < NUM_EVT_LINES; k++) begin : g_emask
    always_ff @(posedge clk) begin
      if (rst) evt_mask_q[k] <= '0;
      else if (reg_wr_en && reg_addr == A_EVT0 + ADDR_W'(k))
        evt_mask_q[k] <= reg_wdata[NUM_CMP-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_mask_q[0] <= '0;
      ien_q         <= '0;
    end else if (reg_wr_en) begin
      if (reg_addr == A_DMA) dma_mask_q[0] <= reg_wdata[NUM_CMP-1:0];
      if (reg_addr == A_IEN) ien_q         <= reg_wdata[NUM_CMP-1:0];
    end
  end

  // Event and DMA routing
  pwm_cmp_route #(.NUM_CMP(NUM_CMP), .NUM_LINES(NUM_EVT_LINES)) evt_route_i (
    .clk    (clk),
    .rst    (rst),
    .hit    (hit),
    .mask   (evt_mask_q),
    .pulse_q(evt_pulse)
  );

  pwm_cmp_route #(.NUM_CMP(NUM_CMP), .NUM_LINES(1)) dma_route_i (
    .clk    (clk),
    .rst    (rst),
    .hit    (hit),
    .mask   (dma_mask_q),
    .pulse_q(dma_pulse)
  );
  assign dma_req = dma_pulse[0];

  // Sticky status and interrupt
  assign stat_rd = reg_rd_en && (reg_addr == A_STAT);

  pwm_cmp_status #(.NUM_CMP(NUM_CMP)) status_i (
    .clk    (clk),
    .rst    (rst),
    .hit    (hit),
    .rd_clr (stat_rd),
    .ien    (ien_q),
    .flags_q(irq_flags),
    .irq_q  (irq)
  );

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd_en) begin
      reg_rdata <= '0;
      if (reg_addr < A_NCMP) begin
        reg_rdata <= DATA_W'(cfg_rd[reg_addr[IDX_W-1:0]]);
      end else begin
        for (int k = 0; k < NUM_EVT_LINES; k++)
          if (reg_addr == A_EVT0 + ADDR_W'(k)) reg_rdata <= DATA_W'(evt_mask_q[k]);
        if (reg_addr == A_DMA)  reg_rdata <= DATA_W'(dma_mask_q[0]);
        if (reg_addr == A_STAT) reg_rdata <= DATA_W'(irq_flags);
        if (reg_addr == A_IEN)  reg_rdata <= DATA_W'(ien_q);
      end
    end
  end
endmodule

// File: rtl/pwm_cmp_evt_chk.sv
module pwm_cmp_evt_chk #(
  parameter int NUM_CMP   = 8,
  parameter int ADDR_W    = 4,
  parameter int NUM_LINES = 2,
  parameter int STAT_ADDR = 11
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cnt_tick,
  input logic                 reg_rd_en,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [NUM_CMP-1:0]   irq_flags,
  input logic                 irq,
  input logic [NUM_LINES-1:0] evt_pulse,
  input logic                 dma_req
);
  logic stat_rd;
  assign stat_rd = reg_rd_en && (reg_addr == ADDR_W'(STAT_ADDR));

  assert_evt_after_tick_R5: assert property (@(posedge clk) disable iff (rst)
    (|evt_pulse) |-> $past(cnt_tick));

  assert_dma_after_tick_R6: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> $past(cnt_tick));

  assert_flag_set_needs_tick_R4: assert property (@(posedge clk) disable iff (rst)
    (|(irq_flags & ~$past(irq_flags))) |-> $past(cnt_tick));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (|($past(irq_flags) & ~irq_flags)) |-> $past(stat_rd));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
    $past(stat_rd && !cnt_tick) |-> (irq_flags == '0));

  assert_irq_has_flag_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|irq_flags));
endmodule

bind pwm_cmp_evt pwm_cmp_evt_chk #(
  .NUM_CMP  (NUM_CMP),
  .ADDR_W   (ADDR_W),
  .NUM_LINES(pwm_cmp_pkg::NUM_EVT_LINES),
  .STAT_ADDR(NUM_CMP + pwm_cmp_pkg::NUM_EVT_LINES + 1)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .cnt_tick (cnt_tick),
  .reg_rd_en(reg_rd_en),
  .reg_addr (reg_addr),
  .irq_flags(irq_flags),
  .irq      (irq),
  .evt_pulse(evt_pulse),
  .dma_req  (dma_req)
);

// File: tb/pwm_cmp_evt_tb_top.sv
module pwm_cmp_evt_tb_top;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_tick = 1'b0;
  logic [15:0] cnt_val = '0;
  logic        cnt_down = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [N-1:0] irq_flags;
  logic        irq;
  logic [1:0]  evt_pulse;
  logic        dma_req;

  int checks = 0;
  int fails  = 0;

  logic [15:0] m_val [N];
  logic        m_en  [N];
  logic        m_bu  [N];
  logic        m_bd  [N];
  logic [N-1:0] m_evt [2];
  logic [N-1:0] m_dma, m_ien, e_flags;

  always #10 clk = ~clk;

  pwm_cmp_evt dut_i (
    .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .cnt_val(cnt_val),
    .cnt_down(cnt_down), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_flags(irq_flags), .irq(irq), .evt_pulse(evt_pulse), .dma_req(dma_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    d = reg_rdata;
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  function automatic logic [N-1:0] model_hit(input logic [15:0] v, input logic dn, input logic tk);
    logic [N-1:0] h;
    h = '0;
    for (int i = 0; i < N; i++)
      h[i] = tk & m_en[i] & (v == m_val[i]) & (dn ? ~m_bd[i] : ~m_bu[i]);
    return h;
  endfunction

  // One cycle of stimulus, optionally with a status read; all outputs checked.
  task automatic step(input logic [15:0] v, input logic dn, input logic tk,
                      input logic rdst, input string req);
    logic [N-1:0] h, old;
    @(negedge clk);
    cnt_val = v; cnt_down = dn; cnt_tick = tk;
    reg_rd_en = rdst; reg_addr = 4'd11;
    h = model_hit(v, dn, tk);
    old = e_flags;
    e_flags = (rdst ? '0 : e_flags) | h;
    @(posedge clk); #1;
    check({req, " evt0 R5"}, 32'(evt_pulse[0]), 32'(|(h & m_evt[0])));
    check({req, " evt1 R5"}, 32'(evt_pulse[1]), 32'(|(h & m_evt[1])));
    check({req, " dma R6"},  32'(dma_req),      32'(|(h & m_dma)));
    check({req, " flags R7"}, 32'(irq_flags),   32'(e_flags));
    check({req, " irq R8"},  32'(irq),          32'(|(e_flags & m_ien)));
    if (rdst) check({req, " rdata R7"}, reg_rdata, 32'(old));
    @(negedge clk);
    cnt_tick = 1'b0; reg_rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state
    #1;
    check("R1 flags", 32'(irq_flags), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 evt", 32'(evt_pulse), 0);
    check("R1 dma", 32'(dma_req), 0);
    for (int a = 0; a < 13; a++) begin
      if (a == 11) continue;
      rd(4'(a), d);
      check("R1 reg zero", d, 0);
    end

    // Configuration: unit i compares with 4*i+3
    for (int i = 0; i < N; i++) begin
      m_val[i] = 16'(4 * i + 3);
      m_en[i]  = (i != 5);            // R3: unit 5 disabled
      m_bu[i]  = (i == 6);            // unit 6 ignores up-count
      m_bd[i]  = (i == 2);            // unit 2 ignores down-count
      wr(4'(i), {13'd0, m_bd[i], m_bu[i], m_en[i], m_val[i]});
    end
    m_evt[0] = 8'h0F; m_evt[1] = 8'hE0; m_dma = 8'h44; m_ien = 8'h09;
    wr(4'd8, 32'(m_evt[0])); wr(4'd9, 32'(m_evt[1]));
    wr(4'd10, 32'(m_dma));   wr(4'd12, 32'(m_ien));
    e_flags = '0;

    // R9: readback
    for (int i = 0; i < N; i++) begin
      rd(4'(i), d);
      check("R9 cfg readback", d, {13'd0, m_bd[i], m_bu[i], m_en[i], m_val[i]});
    end
    rd(4'd8, d);  check("R9 evt0 mask", d, 32'(m_evt[0]));
    rd(4'd9, d);  check("R9 evt1 mask", d, 32'(m_evt[1]));
    rd(4'd10, d); check("R9 dma mask", d, 32'(m_dma));
    rd(4'd12, d); check("R9 ien mask", d, 32'(m_ien));

    // R4: counter equal to compare values but no tick
    for (int i = 0; i < N; i++) step(m_val[i], 1'b0, 1'b0, 1'b0, "R4 no tick");

    // R2/R3/R5/R6: up sweep over all values
    for (int v = 0; v < 40; v++) step(16'(v), 1'b0, 1'b1, 1'b0, "R2 up sweep");

    // R7: read clears flags
    step(16'd1000, 1'b0, 1'b0, 1'b1, "R7 status read");
    step(16'd1000, 1'b0, 1'b0, 1'b0, "R7 after read");

    // R2: down sweep
    for (int v = 40; v >= 0; v--) step(16'(v), 1'b1, 1'b1, 1'b0, "R2 down sweep");

    // R7: read coinciding with a match keeps that match's flag
    step(m_val[3], 1'b0, 1'b1, 1'b1, "R7 read with match");
    step(16'd1000, 1'b0, 1'b0, 1'b1, "R7 final read");

    // R3: disabled unit at its value in both directions
    step(m_val[5], 1'b0, 1'b1, 1'b0, "R3 disabled up");
    step(m_val[5], 1'b1, 1'b1, 1'b0, "R3 disabled down");

    // R8: enable mask change reflected on irq
    wr(4'd12, 32'h0); m_ien = '0;
    step(m_val[0], 1'b0, 1'b1, 1'b0, "R8 masked");
    wr(4'd12, 32'h01); m_ien = 8'h01;
    step(16'd1000, 1'b0, 1'b0, 1'b0, "R8 unmasked");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule